// File: doc/BRIEF.md
# Delayed-Branch Exception Acceptance Controller

This block sits beside an in-order pipeline that issues at most one instruction per cycle. It decides the instruction boundary at which an exception is taken when that exception was flagged at decode. For each decoded instruction it receives a vector of cause flags, an 8-bit trap immediate, and delayed-branch information: whether the instruction is a delayed branch, whether that branch is conditional, whether the condition holds, and the branch target. Each cause has a fixed type. A re-execution cause restarts the faulting instruction. A completion cause resumes after it.

No exception may be taken between a delayed branch and its delay slot. A re-execution fault in the slot is taken before the branch, so the branch and the slot replay together. A completion fault in the branch or in the slot is taken only after the branch pair has finished. When the block accepts an exception it raises a one-cycle strobe, which flushes the younger stages. It also presents the re-execute flag and the return address, loads a 12-bit event code, and for a trap loads the trap immediate into an 8-bit register. The code and trap registers hold their values until the next accepted exception.

Top module: `exc_accept_ctrl`

## Requirements
- R1: After reset, the strobe, the re-execute flag, the return address and the trap register read 0, and the event code reads 0x000.
- R2: A re-execution cause on an instruction outside any branch pair raises the strobe on the clock edge after decode, with re-execute 1 and return address equal to that instruction's address.
- R3: A completion cause on an instruction outside any branch pair raises the strobe on the edge after decode, with re-execute 0 and return address equal to its address plus STEP (2).
- R4: A completion cause on a delayed branch that has a slot gives no strobe at the branch. The strobe comes after the slot is decoded, with the branch's code, re-execute 0 and return address equal to the branch target.
- R5: A re-execution cause on a delay-slot instruction gives re-execute 1 and a return address equal to the branch's address.
- R6: A completion cause on a delay-slot instruction gives re-execute 0 and a return address equal to the branch target.
- R7: A conditional delayed branch whose condition is false creates no slot. It and the instruction after it are each treated as ordinary instructions.
- R8: Cause bit i has priority over every bit above i, and the lowest set bit chooses the code. The bits and codes are: 0 TLB miss load 0x040, 1 TLB miss store 0x060, 2 initial page write 0x080, 3 TLB protect load 0x0A0, 4 TLB protect store 0x0C0, 5 address error load 0x0E0, 6 address error store 0x100, 7 trap 0x160, 8 reserved instruction 0x180, 9 illegal slot 0x1A0, 10 user break 0x1E0, 11 DMA address error 0x5C0. Bits 7, 10 and 11 are completion causes and the rest are re-execution causes.
- R9: When a deferred completion cause from a branch meets a cause in its slot, the branch's older cause is taken.
- R10: The trap register loads the trap immediate only when bit 7 is the accepted cause. The trap register and the event code keep their values between accepts.
- R11: The strobe lasts exactly one cycle. An instruction presented while the strobe is high is ignored, because it is being flushed.
- R12: A re-execution cause on a delayed branch is taken before the branch, with re-execute 1 and return address equal to the branch address. No slot stays pending, so the next instruction is handled as an ordinary one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid_i | input | 1 | An instruction is at decode this cycle |
| dec_pc_i | input | AW | Address of the decoded instruction |
| dec_cause_i | input | 12 | Exception cause flags, one bit per cause |
| dec_imm_i | input | 8 | Trap immediate of the decoded instruction |
| dec_dbr_i | input | 1 | Decoded instruction is a delayed branch |
| dec_cond_i | input | 1 | The delayed branch is conditional |
| dec_taken_i | input | 1 | Condition of a conditional delayed branch is true |
| dec_tgt_i | input | AW | Target of the delayed branch |
| acc_o | output | 1 | One-cycle exception accept and flush strobe |
| reexec_o | output | 1 | 1: re-execute at the return address, 0: continue there |
| ret_pc_o | output | AW | Saved return address |
| code_o | output | 12 | Event code register |
| trap_o | output | 8 | Trap immediate register |

## Verification
The assertions assume that no instruction presented in a delay slot is itself treated as a branch. They also assume that the branch condition is already resolved when the branch is at decode, and that any instruction presented in the cycle the strobe is high is a flushed one. The bench keeps to these assumptions. It gives every branch its slot before any other branch, sets the condition flags together with the branch, and inserts an idle cycle after each accept. The one exception to the idle cycle is the flush scenario, which deliberately presents a faulting instruction during the strobe.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;
  localparam int NCAUSE = 12;
  localparam int CIDX_W = $clog2(NCAUSE);
  localparam int CODE_W = 12;
  localparam int TRAP_W = 8;
  localparam int C_TRAP = 7;
  localparam logic [CODE_W-1:0] RESET_CODE = 12'h000;

  // event code per cause index; lower index = higher priority
  function automatic logic [CODE_W-1:0] cause_code(input logic [CIDX_W-1:0] idx);
    logic [CODE_W-1:0] c;
    case (idx)
      4'd0:    c = 12'h040;
      4'd1:    c = 12'h060;
      4'd2:    c = 12'h080;
      4'd3:    c = 12'h0A0;
      4'd4:    c = 12'h0C0;
      4'd5:    c = 12'h0E0;
      4'd6:    c = 12'h100;
      4'd7:    c = 12'h160;
      4'd8:    c = 12'h180;
      4'd9:    c = 12'h1A0;
      4'd10:   c = 12'h1E0;
      4'd11:   c = 12'h5C0;
      default: c = 12'h000;
    endcase
    return c;
  endfunction

  // completion causes resume after the instruction; all others restart it
  function automatic logic cause_is_compl(input logic [CIDX_W-1:0] idx);
    return (idx == CIDX_W'(C_TRAP)) || (idx == CIDX_W'(10)) || (idx == CIDX_W'(11));
  endfunction
endpackage

// File: rtl/exc_cause_prio.sv
module exc_cause_prio #(
  parameter int NC   = 12,
  parameter int CW   = 4
) (
  input  logic [NC-1:0] vec_i,
  output logic          any_o,
  output logic [CW-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = CW'(i);
    end
  end

  // R8: the chosen bit is set and no lower bit is set
  logic lower_hit;
  always_comb begin
    lower_hit = 1'b0;
    for (int j = 0; j < NC; j++) begin
      if ((CW'(j) < idx_o) && vec_i[j]) lower_hit = 1'b1;
    end
    if (any_o) begin
      assert_prio_pick_R8: assert (vec_i[idx_o] && !lower_hit);
    end
  end
endmodule

// File: rtl/exc_slot_track.sv
module exc_slot_track #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [AW-1:0] br_pc_i,
  input  logic [AW-1:0] br_tgt_i,
  input  logic          def_i,
  input  logic [CW-1:0] def_idx_i,
  input  logic [TW-1:0] def_imm_i,
  output logic          pend_o,
  output logic [AW-1:0] br_pc_o,
  output logic [AW-1:0] br_tgt_o,
  output logic          def_o,
  output logic [CW-1:0] def_idx_o,
  output logic [TW-1:0] def_imm_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o    <= 1'b0;
      def_o     <= 1'b0;
      br_pc_o   <= '0;
      br_tgt_o  <= '0;
      def_idx_o <= '0;
      def_imm_o <= '0;
    end else if (clr_i) begin
      pend_o <= 1'b0;
      def_o  <= 1'b0;
    end else if (set_i) begin
      pend_o    <= 1'b1;
      br_pc_o   <= br_pc_i;
      br_tgt_o  <= br_tgt_i;
      def_o     <= def_i;
      def_idx_o <= def_idx_i;
      def_imm_o <= def_imm_i;
    end
  end

  // R9: a deferred cause only exists while a slot is awaited
  assert_def_needs_slot_R9: assert property (@(posedge clk) disable iff (rst)
    def_o |-> pend_o);
endmodule

// File: rtl/exc_event_regs.sv
module exc_event_regs #(
  parameter int AW = 32,
  parameter int KW = 12,
  parameter int TW = 8,
  parameter logic [KW-1:0] RST_CODE = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_i,
  input  logic          reexec_i,
  input  logic [AW-1:0] ret_i,
  input  logic [KW-1:0] code_i,
  input  logic          trap_ld_i,
  input  logic [TW-1:0] imm_i,
  output logic          acc_o,
  output logic          reexec_o,
  output logic [AW-1:0] ret_o,
  output logic [KW-1:0] code_o,
  output logic [TW-1:0] trap_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o    <= 1'b0;
      reexec_o <= 1'b0;
      ret_o    <= '0;
      code_o   <= RST_CODE;
      trap_o   <= '0;
    end else begin
      acc_o <= take_i;
      if (take_i) begin
        reexec_o <= reexec_i;
        ret_o    <= ret_i;
        code_o   <= code_i;
        if (trap_ld_i) trap_o <= imm_i;
      end
    end
  end

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (rst)
    acc_o |=> !acc_o);
  assert_code_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !acc_o |-> $stable(code_o));
  assert_trap_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !acc_o |-> $stable(trap_o));
endmodule

// File: rtl/exc_accept_ctrl.sv
module exc_accept_ctrl
  import exc_ctl_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_valid_i,
  input  logic [AW-1:0]     dec_pc_i,
  input  logic [NCAUSE-1:0] dec_cause_i,
  input  logic [TRAP_W-1:0] dec_imm_i,
  input  logic              dec_dbr_i,
  input  logic              dec_cond_i,
  input  logic              dec_taken_i,
  input  logic [AW-1:0]     dec_tgt_i,
  output logic              acc_o,
  output logic              reexec_o,
  output logic [AW-1:0]     ret_pc_o,
  output logic [CODE_W-1:0] code_o,
  output logic [TRAP_W-1:0] trap_o
);
  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  logic              p_any, p_cmp;
  logic [CIDX_W-1:0] p_idx;

  exc_cause_prio #(.NC(NCAUSE), .CW(CIDX_W)) u_prio (
    .vec_i (dec_cause_i),
    .any_o (p_any),
    .idx_o (p_idx)
  );
  assign p_cmp = cause_is_compl(p_idx);

  logic              s_pend, d_vld;
  logic [AW-1:0]     s_pc, s_tgt;
  logic [CIDX_W-1:0] d_idx;
  logic [TRAP_W-1:0] d_imm;
  logic              s_set, s_clr, d_set;

  exc_slot_track #(.AW(AW), .CW(CIDX_W), .TW(TRAP_W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .set_i     (s_set),
    .clr_i     (s_clr),
    .br_pc_i   (dec_pc_i),
    .br_tgt_i  (dec_tgt_i),
    .def_i     (d_set),
    .def_idx_i (p_idx),
    .def_imm_i (dec_imm_i),
    .pend_o    (s_pend),
    .br_pc_o   (s_pc),
    .br_tgt_o  (s_tgt),
    .def_o     (d_vld),
    .def_idx_o (d_idx),
    .def_imm_o (d_imm)
  );

  logic              live, slot_mk;
  logic              take, t_reexec, t_trap_ld;
  logic [CIDX_W-1:0] t_idx;
  logic [AW-1:0]     t_ret;
  logic [TRAP_W-1:0] t_imm;
  logic [CODE_W-1:0] t_code;

  // instructions arriving during the strobe are being flushed
  assign live    = dec_valid_i && !acc_o;
  assign slot_mk = dec_dbr_i && (!dec_cond_i || dec_taken_i);

  always_comb begin
    take     = 1'b0;
    t_reexec = 1'b0;
    t_idx    = p_idx;
    t_imm    = dec_imm_i;
    t_ret    = dec_pc_i;
    s_set    = 1'b0;
    s_clr    = 1'b0;
    d_set    = 1'b0;
    if (live) begin
      if (s_pend) begin
        // this is the slot: the pair has reached its far boundary
        s_clr = 1'b1;
        if (d_vld) begin
          take  = 1'b1;
          t_idx = d_idx;
          t_imm = d_imm;
          t_ret = s_tgt;
        end else if (p_any) begin
          take     = 1'b1;
          t_reexec = !p_cmp;
          t_ret    = p_cmp ? s_tgt : s_pc;
        end
      end else if (slot_mk) begin
        if (p_any && !p_cmp) begin
          take     = 1'b1;
          t_reexec = 1'b1;
          t_ret    = dec_pc_i;
        end else begin
          s_set = 1'b1;
          d_set = p_any;
        end
      end else if (p_any) begin
        take     = 1'b1;
        t_reexec = !p_cmp;
        t_ret    = p_cmp ? dec_pc_i + STEP_W : dec_pc_i;
      end
    end
  end

  assign t_code    = cause_code(t_idx);
  assign t_trap_ld = take && (t_idx == CIDX_W'(C_TRAP));

  exc_event_regs #(.AW(AW), .KW(CODE_W), .TW(TRAP_W), .RST_CODE(RESET_CODE)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .take_i    (take),
    .reexec_i  (t_reexec),
    .ret_i     (t_ret),
    .code_i    (t_code),
    .trap_ld_i (t_trap_ld),
    .imm_i     (t_imm),
    .acc_o     (acc_o),
    .reexec_o  (reexec_o),
    .ret_o     (ret_pc_o),
    .code_o    (code_o),
    .trap_o    (trap_o)
  );

  // R4: the edge that opens a branch pair never carries an accept
  assert_no_accept_at_branch_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(s_pend) |-> !acc_o);
  // R11: a pair is never left open across an accept
  assert_pair_closed_on_accept_R11: assert property (@(posedge clk) disable iff (rst)
    acc_o |-> !s_pend);
endmodule

// File: tb/tb_exc_accept_ctrl.sv
module tb_exc_accept_ctrl;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dec_valid_i = 1'b0;
  logic [AW-1:0] dec_pc_i = '0;
  logic [11:0]   dec_cause_i = '0;
  logic [7:0]    dec_imm_i = '0;
  logic          dec_dbr_i = 1'b0;
  logic          dec_cond_i = 1'b0;
  logic          dec_taken_i = 1'b0;
  logic [AW-1:0] dec_tgt_i = '0;
  logic          acc_o, reexec_o;
  logic [AW-1:0] ret_pc_o;
  logic [11:0]   code_o;
  logic [7:0]    trap_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  exc_accept_ctrl #(.AW(AW), .STEP(2)) dut (
    .clk(clk), .rst(rst), .dec_valid_i(dec_valid_i), .dec_pc_i(dec_pc_i),
    .dec_cause_i(dec_cause_i), .dec_imm_i(dec_imm_i), .dec_dbr_i(dec_dbr_i),
    .dec_cond_i(dec_cond_i), .dec_taken_i(dec_taken_i), .dec_tgt_i(dec_tgt_i),
    .acc_o(acc_o), .reexec_o(reexec_o), .ret_pc_o(ret_pc_o), .code_o(code_o),
    .trap_o(trap_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one decode slot at a falling edge; return one cycle later at the next falling edge
  task automatic step(input bit v, input logic [31:0] pc, input logic [11:0] cs,
                      input logic [7:0] imm, input bit br, input bit cond,
                      input bit tk, input logic [31:0] tgt);
    dec_valid_i = v; dec_pc_i = pc; dec_cause_i = cs; dec_imm_i = imm;
    dec_dbr_i = br; dec_cond_i = cond; dec_taken_i = tk; dec_tgt_i = tgt;
    @(negedge clk);
    dec_valid_i = 1'b0; dec_cause_i = '0; dec_dbr_i = 1'b0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    check("R1 acc", acc_o, 0);
    check("R1 reexec", reexec_o, 0);
    check("R1 ret", ret_pc_o, 0);
    check("R1 code", code_o, 32'h000);
    check("R1 trap", trap_o, 0);
  endtask

  task automatic t_plain_reexec();
    step(1, 32'h100, 12'h020, 0, 0, 0, 0, 0);   // bit5
    check("R2 acc", acc_o, 1);
    check("R2 reexec", reexec_o, 1);
    check("R2 ret", ret_pc_o, 32'h100);
    check("R2 code", code_o, 32'h0E0);
    idle();
    check("R11 strobe one cycle", acc_o, 0);
    check("R10 code held", code_o, 32'h0E0);
  endtask

  task automatic t_plain_compl();
    step(1, 32'h200, 12'h080, 8'h5A, 0, 0, 0, 0); // bit7 trap
    check("R3 acc", acc_o, 1);
    check("R3 reexec", reexec_o, 0);
    check("R3 ret", ret_pc_o, 32'h202);
    check("R3 code", code_o, 32'h160);
    check("R10 trap load", trap_o, 32'h5A);
    idle();
  endtask

  task automatic t_prio();
    step(1, 32'h280, 12'h908, 8'hEE, 0, 0, 0, 0); // bits 3, 8, 11
    check("R8 code", code_o, 32'h0A0);
    check("R8 reexec", reexec_o, 1);
    check("R10 trap kept", trap_o, 32'h5A);
    idle();
    step(1, 32'h290, 12'hC80, 8'h11, 0, 0, 0, 0); // bits 7, 10, 11
    check("R8 trap wins", code_o, 32'h160);
    check("R10 trap load 2", trap_o, 32'h11);
    idle();
  endtask

  task automatic t_branch_compl();
    step(1, 32'h300, 12'h400, 0, 1, 0, 0, 32'h400); // user break on branch
    check("R4 no accept at branch", acc_o, 0);
    step(1, 32'h302, 12'h000, 0, 0, 0, 0, 0);
    check("R4 acc after slot", acc_o, 1);
    check("R4 code", code_o, 32'h1E0);
    check("R4 ret", ret_pc_o, 32'h400);
    check("R4 reexec", reexec_o, 0);
    idle();
  endtask

  task automatic t_slot_reexec();
    step(1, 32'h500, 12'h000, 0, 1, 1, 1, 32'h600);
    check("R5 none at branch", acc_o, 0);
    step(1, 32'h502, 12'h002, 0, 0, 0, 0, 0);   // bit1
    check("R5 acc", acc_o, 1);
    check("R5 reexec", reexec_o, 1);
    check("R5 ret branch", ret_pc_o, 32'h500);
    check("R5 code", code_o, 32'h060);
    idle();
  endtask

  task automatic t_slot_compl();
    step(1, 32'h700, 12'h000, 0, 1, 0, 0, 32'h800);
    idle();
    check("R6 gap keeps quiet", acc_o, 0);
    step(1, 32'h702, 12'h800, 0, 0, 0, 0, 0);   // bit11
    check("R6 acc", acc_o, 1);
    check("R6 reexec", reexec_o, 0);
    check("R6 ret target", ret_pc_o, 32'h800);
    check("R6 code", code_o, 32'h5C0);
    idle();
  endtask

  task automatic t_not_taken();
    step(1, 32'h900, 12'h000, 0, 1, 1, 0, 32'h950);
    check("R7 acc", acc_o, 0);
    step(1, 32'h902, 12'h001, 0, 0, 0, 0, 0);   // bit0
    check("R7 ret own", ret_pc_o, 32'h902);
    check("R7 reexec", reexec_o, 1);
    check("R7 code", code_o, 32'h040);
    idle();
    step(1, 32'hA00, 12'h080, 8'h33, 1, 1, 0, 32'hA50);
    check("R7 nt branch compl acc", acc_o, 1);
    check("R7 nt branch ret", ret_pc_o, 32'hA02);
    idle();
  endtask

  task automatic t_older_wins();
    step(1, 32'hB00, 12'h080, 8'h77, 1, 0, 0, 32'hC00);
    check("R9 none at branch", acc_o, 0);
    step(1, 32'hB02, 12'h001, 8'h99, 0, 0, 0, 0);
    check("R9 code", code_o, 32'h160);
    check("R9 trap", trap_o, 32'h77);
    check("R9 ret", ret_pc_o, 32'hC00);
    check("R9 reexec", reexec_o, 0);
    idle();
  endtask

  task automatic t_flush();
    step(1, 32'hD00, 12'h004, 0, 0, 0, 0, 0);   // bit2
    check("R11 acc", acc_o, 1);
    step(1, 32'hD02, 12'h001, 0, 0, 0, 0, 0);   // during strobe
    check("R11 flushed ignored", acc_o, 0);
    check("R11 code unchanged", code_o, 32'h080);
    idle();
    check("R11 still quiet", acc_o, 0);
  endtask

  task automatic t_branch_reexec();
    step(1, 32'hE00, 12'h040, 0, 1, 0, 0, 32'hF00); // bit6
    check("R12 acc", acc_o, 1);
    check("R12 reexec", reexec_o, 1);
    check("R12 ret", ret_pc_o, 32'hE00);
    check("R12 code", code_o, 32'h100);
    idle();
    step(1, 32'hE02, 12'h080, 8'h44, 0, 0, 0, 0);
    check("R12 next is ordinary", ret_pc_o, 32'hE04);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain_reexec();
    t_plain_compl();
    t_prio();
    t_branch_compl();
    t_slot_reexec();
    t_slot_compl();
    t_not_taken();
    t_older_wins();
    t_flush();
    t_branch_reexec();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule